// File: doc/BRIEF.md
# Motor Tachometer Speed Discriminator with Lock Detect

This block compares the period of a motor's tachometer pulse train against a reference clock. The reference is divided by a prescaler, and the resulting ticks are counted between consecutive rising edges of the tachometer input. Every second completed tachometer period is measured and turned into a verdict, which is published. The verdict has two parts: a direction bit that asks the speed loop to speed up or slow down, and an active-low lock flag that is low while the measured period sits inside a symmetric window of one sixteenth around the nominal count. At the default settings (prescale 16, nominal 512 ticks) the target tachometer frequency is the reference frequency divided by 8192.

The raw measured count also leaves the block on a valid/ready stream. A result waits on the output until it is accepted. If the consumer does not take it before the next measurement, the newer result replaces it, so the consumer always sees the latest count. Back-pressure never stalls the measurement, and the direction and lock pins do not depend on `m_ready`. If the motor stalls, the period counter saturates before another edge arrives. The verdict then goes straight to "too slow, unlocked" and waits for new edges.

Top module: `fg_speed_discrim`

## Requirements
- R1: After reset, `accel` is 1, `lock_n` is 1 and `m_valid` is 0.
- R2: The measured count is the number of clock cycles between two rising tachometer edges divided by PRESCALE and rounded down. It saturates at 2^CNT_W−1. Falling edges delimit nothing.
- R3: The first rising edge after reset only starts timing. From then on, results are published on the third, fifth, seventh rising edge and so on. Each published result measures the period that just ended. The periods that end on the second, fourth, … edges are discarded and change no output.
- R4: When a result is published, `accel` becomes 1 if the count is greater than NOMINAL, and 0 if the count is NOMINAL or less.
- R5: When a result is published, `lock_n` becomes 0 if the count lies within NOMINAL ± (NOMINAL >> 4), with both ends included. Otherwise `lock_n` becomes 1.
- R6: If the running count reaches saturation with no rising edge, `accel` becomes 1 and `lock_n` becomes 1 at once. No result is published and `m_data` keeps its value.
- R7: Each published result drives `m_data` and raises `m_valid`. Both hold until a cycle with `m_valid` and `m_ready` both high, after which `m_valid` drops. A newer result overwrites one that has not been accepted. `m_ready` has no effect on `accel` or `lock_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fg_in | input | 1 | Tachometer pulse input, asynchronous |
| accel | output | 1 | 1 requests acceleration, 0 requests deceleration |
| lock_n | output | 1 | 0 while speed is inside the lock window |
| m_valid | output | 1 | Measured-count stream valid |
| m_ready | input | 1 | Measured-count stream ready |
| m_data | output | CNT_W | Measured period in prescaled ticks |

## Verification
The hardest behaviour to see from the ports is the discarded period between two published results. Its only evidence is that nothing changes. The stimulus places a far-off-speed period in the discarded slot, right after a locked result, and checks that lock and direction hold before the next publishing edge. The stall timeout also needs a locked state first. The stimulus then stops the tachometer and samples once shortly before saturation and once shortly after it.

// File: rtl/fsd_pkg.sv
`timescale 1ns/1ps
package fsd_pkg;

  typedef struct packed {
    logic accel;
    logic lock_n;
  } fsd_verdict_t;

  // Verdict from one measured period against nominal and window bounds.
  function automatic fsd_verdict_t judge(input int unsigned count,
                                         input int unsigned nominal,
                                         input int unsigned lo,
                                         input int unsigned hi);
    fsd_verdict_t v;
    v.accel  = (count > nominal);
    v.lock_n = !((count >= lo) && (count <= hi));
    return v;
  endfunction

endpackage

// File: rtl/fsd_edge_sync.sv
`timescale 1ns/1ps
module fsd_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;

endmodule

// File: rtl/fsd_prescaler.sv
`timescale 1ns/1ps
module fsd_prescaler #(
  parameter int PRESCALE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  generate
    if (PRESCALE == 1) begin : g_bypass
      logic unused_restart;
      assign unused_restart = restart;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] ph;

      assign tick = (ph == LAST);

      always_ff @(posedge clk) begin
        if (!rst_n || restart) ph <= '0;
        else if (tick)         ph <= '0;
        else                   ph <= ph + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/fsd_period_cnt.sv
`timescale 1ns/1ps
module fsd_period_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_next,
  output logic             sat
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  // Count including the tick of the present cycle.
  assign cnt_next = (tick && cnt_q != CMAX) ? cnt_q + 1'b1 : cnt_q;
  assign sat      = (cnt_next == CMAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else                 cnt_q <= cnt_next;
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && cnt_q == CMAX) |=> (cnt_q == CMAX)); // R6

endmodule

// File: rtl/fg_speed_discrim.sv
`timescale 1ns/1ps
module fg_speed_discrim #(
  parameter int PRESCALE   = 16,
  parameter int NOMINAL    = 512,
  parameter int LOCK_SHIFT = 4,
  parameter int CNT_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fg_in,
  output logic             accel,
  output logic             lock_n,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [CNT_W-1:0] m_data
);
  import fsd_pkg::*;

  localparam int WIN = NOMINAL >> LOCK_SHIFT;
  localparam int LO  = NOMINAL - WIN;
  localparam int HI  = NOMINAL + WIN;

  logic             fg_rise;
  logic             tick;
  logic [CNT_W-1:0] cnt_next;
  logic             sat;
  logic             armed, phase;
  fsd_verdict_t     verdict;

  fsd_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .din(fg_in), .rise(fg_rise)
  );

  fsd_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(fg_rise), .tick(tick)
  );

  fsd_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(fg_rise), .tick(tick),
    .cnt_next(cnt_next), .sat(sat)
  );

  assign verdict = judge(int'(cnt_next), NOMINAL, LO, HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      phase   <= 1'b0;
      accel   <= 1'b1;
      lock_n  <= 1'b1;
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (fg_rise) begin
        if (!armed) begin
          armed <= 1'b1;
          phase <= 1'b0;
        end else begin
          phase <= ~phase;
          if (phase) begin
            m_data  <= cnt_next;
            m_valid <= 1'b1;
            accel   <= verdict.accel;
            lock_n  <= verdict.lock_n;
          end
        end
      end else if (sat) begin
        accel  <= 1'b1;
        lock_n <= 1'b1;
      end
    end
  end

  AST_VALID_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(fg_rise)); // R3

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid); // R7

  AST_LOCK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_n |-> (int'(m_data) >= LO && int'(m_data) <= HI)); // R5

  AST_LOCKED_ACCEL_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_n && accel) |-> (int'(m_data) > NOMINAL)); // R4

endmodule

// File: tb/sim_fg_speed_discrim.sv
`timescale 1ns/1ps
module sim_fg_speed_discrim;
  localparam int PS  = 4;
  localparam int NOM = 32;
  localparam int CW  = 6;
  localparam int NV  = 10;

  // ticks per period, expected accel, expected lock_n
  localparam int VT[NV] = '{32, 33, 34, 35, 31, 30, 29, 20, 50, 63};
  localparam int VA[NV] = '{ 0,  1,  1,  1,  0,  0,  0,  0,  1,  1};
  localparam int VL[NV] = '{ 0,  0,  0,  1,  0,  0,  1,  1,  1,  1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fg_in = 1'b0;
  logic m_ready = 1'b0;
  logic accel, lock_n, m_valid;
  logic [CW-1:0] m_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fg_speed_discrim #(.PRESCALE(PS), .NOMINAL(NOM), .LOCK_SHIFT(4), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .fg_in(fg_in), .accel(accel), .lock_n(lock_n),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fg_in = 1'b0;
    m_ready = 1'b0;
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(2);
  endtask

  // One tachometer period of 'ticks' prescaled ticks, starting with a rising edge.
  task automatic fg_period(input int ticks);
    fg_in = 1'b1;
    wait_clks(2);
    fg_in = 1'b0;
    wait_clks(ticks * PS - 2);
  endtask

  initial begin
    do_reset();
    check("R1 accel", int'(accel), 1);
    check("R1 lock_n", int'(lock_n), 1);
    check("R1 m_valid", int'(m_valid), 0);

    // Table: three edges per vector, published result is the second period.
    for (int i = 0; i < NV; i++) begin
      do_reset();
      fg_period(VT[i]);
      fg_period(VT[i]);
      fg_period(VT[i]);
      check($sformatf("R2 m_data t=%0d", VT[i]), int'(m_data), VT[i]);
      check($sformatf("R4 accel t=%0d", VT[i]), int'(accel), VA[i]);
      check($sformatf("R5 lock_n t=%0d", VT[i]), int'(lock_n), VL[i]);
      check($sformatf("R7 m_valid t=%0d", VT[i]), int'(m_valid), 1);
    end

    // Publishing cadence and discarded periods.
    do_reset();
    fg_period(32);
    fg_period(32);
    check("R3 no result after first period", int'(m_valid), 0);
    check("R3 lock unchanged", int'(lock_n), 1);
    fg_period(50);
    check("R3 locked after edge 3", int'(lock_n), 0);
    check("R3 data after edge 3", int'(m_data), 32);
    fg_period(20);
    check("R3 discarded slow period keeps lock", int'(lock_n), 0);
    check("R3 discarded slow period keeps accel", int'(accel), 0);
    check("R3 discarded period keeps data", int'(m_data), 32);
    fg_period(32);
    check("R7 overwrite unaccepted data", int'(m_data), 20);
    check("R5 fast unlocked", int'(lock_n), 1);
    check("R4 fast decelerates", int'(accel), 0);

    // Handshake.
    check("R7 valid held without ready", int'(m_valid), 1);
    m_ready = 1'b1;
    wait_clks(1);
    m_ready = 1'b0;
    wait_clks(1);
    check("R7 valid drops after accept", int'(m_valid), 0);

    // Stall timeout.
    do_reset();
    fg_period(32);
    fg_period(32);
    fg_period(32);
    check("R6 locked before stall", int'(lock_n), 0);
    wait_clks(100);
    check("R6 no early timeout lock", int'(lock_n), 0);
    check("R6 no early timeout accel", int'(accel), 0);
    wait_clks(60);
    check("R6 timeout unlocks", int'(lock_n), 1);
    check("R6 timeout accelerates", int'(accel), 1);
    check("R6 timeout keeps data", int'(m_data), 32);
    check("R7 ready does not gate verdict", int'(m_valid), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule